// File: doc/BRIEF.md
# Two-Way Address Translation Cache with Trap-Driven Refill

This block caches virtual-to-physical page mappings for a 40-bit virtual address space with 16 KB pages and a 36-bit physical address space. Each lookup takes a virtual address and an access kind: read, write, or instruction fetch. One clock later the block reports one of three outcomes. A hit returns the translated physical address. A miss raises a trap so that software can load the mapping. A protection fault is raised when the entry exists but does not permit the access.

The address is split into a page offset, a set index and a tag. The low 14 bits are the page offset. The next 8 bits select one of 256 sets. The top 18 bits form the tag. Each set holds two entries. An entry stores a valid flag, a dirty flag, a referenced flag, two permission bits, the tag and a 22-bit physical page number.

Software loads entries through a refill port. It may name the way to write, or let a per-set replacement bit choose the least recently used way. A single command clears every referenced flag. The block never walks page tables and never writes pages back to storage.

Top module: `xlate_cache`

## Requirements
- R1: `rs_valid` is `lk_valid` delayed by one clock. On a hit, `rs_paddr` equals the stored physical page number concatenated with the low 14 address bits, in the cycle after the lookup.
- R2: A lookup whose set holds no valid entry with a matching tag (tag = address bits 39..22, set = bits 21..14) raises `rs_trap`. In that case `rs_hit`, `rs_fault`, `rs_way`, `rs_dirty`, `rs_ref` and `rs_paddr` are all zero.
- R3: A refill with `fill_pick`=1 writes the named way of `fill_set`. The new entry is valid, holds the given tag, page and rights, and has its dirty and referenced flags cleared.
- R4: A refill with `fill_pick`=0 writes the way named by the set's replacement bit. That bit is 0 after reset. After a permitted hit or a refill it names the other way.
- R5: A permitted write hit sets the entry's dirty flag. `rs_dirty` reports the flag as it was before the access.
- R6: A permitted hit sets the entry's referenced flag. `rs_ref` reports the flag as it was before the access.
- R7: `ref_clear` clears every referenced flag. A permitted hit in the same cycle still leaves its own entry's flag set.
- R8: Rights bit 0 permits writes and rights bit 1 permits fetches; reads are always permitted. A write to an entry without bit 0, or a fetch from an entry without bit 1, gives `rs_fault` with `rs_hit`=0 and `rs_trap`=0. Such an access leaves the dirty flag, the referenced flag and the replacement bit unchanged.
- R9: After reset every entry is invalid, so every lookup misses, and `rs_valid` is 0.
- R10: A lookup in the same cycle as a refill sees the entries as they were before that refill.
- R11: On a hit, `rs_way` gives the way that matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_write | input | 1 | Lookup is a write |
| lk_exec | input | 1 | Lookup is an instruction fetch |
| fill_en | input | 1 | Refill request this cycle |
| fill_set | input | IDX_W | Set to refill |
| fill_pick | input | 1 | 1: use `fill_way`; 0: use the replacement bit |
| fill_way | input | 1 | Way to write when `fill_pick` is 1 |
| fill_tag | input | TAG_W | Tag of the new entry |
| fill_ppn | input | PPN_W | Physical page number of the new entry |
| fill_rights | input | 2 | Bit 0 write permit, bit 1 fetch permit |
| ref_clear | input | 1 | Clear all referenced flags |
| rs_valid | output | 1 | Result present |
| rs_hit | output | 1 | Translation succeeded |
| rs_trap | output | 1 | Miss; software refill needed |
| rs_fault | output | 1 | Access not permitted by entry rights |
| rs_way | output | 1 | Way that hit |
| rs_dirty | output | 1 | Dirty flag of the hit entry before the access |
| rs_ref | output | 1 | Referenced flag of the hit entry before the access |
| rs_paddr | output | PA_W | Translated physical address |

## Verification
Every outcome of a lookup is due exactly one rising edge after the request. The bench therefore drives each request at a falling edge and reads all result ports at the next falling edge. Effects on stored state are visible only to requests issued after that edge: a refill, a dirty or referenced update, a clear, or a replacement-bit change. The bench keeps a per-entry expectation that is applied only after the current request's outcome has been predicted. This ordering is also how the same-cycle refill case is checked. The sweep runs over a reduced 8-set configuration, covering every set with each access kind, several offsets, both refill modes and the clear command.

// File: rtl/xc_pkg.sv
package xc_pkg;
    localparam int WAYS     = 2;
    localparam int RT_W     = 2;
    localparam int RT_WRITE = 0;
    localparam int RT_EXEC  = 1;

    typedef logic [RT_W-1:0] rights_t;

    // Reads are always allowed; writes and fetches need their permit bit.
    function automatic logic access_ok(rights_t rt, logic wr, logic ex);
        return !(wr && !rt[RT_WRITE]) && !(ex && !rt[RT_EXEC]);
    endfunction
endpackage

// File: rtl/xc_way_cmp.sv
module xc_way_cmp
    import xc_pkg::*;
#(
    parameter int TAG_W = 18
) (
    input  logic             ent_vld,
    input  logic [TAG_W-1:0] ent_tag,
    input  rights_t          ent_rt,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             req_wr,
    input  logic             req_ex,
    output logic             match,
    output logic             allow
);
    assign match = ent_vld && (ent_tag == req_tag);
    assign allow = access_ok(ent_rt, req_wr, req_ex);
endmodule

// File: rtl/xc_array.sv
module xc_array
    import xc_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int TAG_W = 18,
    parameter int PPN_W = 22
) (
    input  logic                            clk,
    input  logic                            rst_n,
    // read port for the lookup set
    input  logic [IDX_W-1:0]                rd_set,
    output logic [WAYS-1:0]                 rd_vld,
    output logic [WAYS-1:0][TAG_W-1:0]      rd_tag,
    output logic [WAYS-1:0][PPN_W-1:0]      rd_ppn,
    output logic [WAYS-1:0][RT_W-1:0]       rd_rt,
    output logic [WAYS-1:0]                 rd_dirty,
    output logic [WAYS-1:0]                 rd_ref,
    // status update from a permitted hit
    input  logic                            upd_en,
    input  logic [IDX_W-1:0]                upd_set,
    input  logic                            upd_way,
    input  logic                            upd_write,
    input  logic                            clr_ref,
    // refill
    input  logic                            rf_en,
    input  logic [IDX_W-1:0]                rf_set,
    input  logic                            rf_use_way,
    input  logic                            rf_way,
    input  logic [TAG_W-1:0]                rf_tag,
    input  logic [PPN_W-1:0]                rf_ppn,
    input  rights_t                         rf_rt
);
    localparam int SETS = 1 << IDX_W;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]            vld;
        logic [SETS-1:0][WAYS-1:0]            dirty;
        logic [SETS-1:0][WAYS-1:0]            refb;
        logic [SETS-1:0][WAYS-1:0][RT_W-1:0]  rt;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0][WAYS-1:0][PPN_W-1:0] ppn;
        logic [SETS-1:0]                      lru;  // way to replace next
    } store_t;

    store_t st_d, st_q;
    logic   rf_way_eff;

    assign rd_vld   = st_q.vld[rd_set];
    assign rd_tag   = st_q.tag[rd_set];
    assign rd_ppn   = st_q.ppn[rd_set];
    assign rd_rt    = st_q.rt[rd_set];
    assign rd_dirty = st_q.dirty[rd_set];
    assign rd_ref   = st_q.refb[rd_set];

    assign rf_way_eff = rf_use_way ? rf_way : st_q.lru[rf_set];

    always_comb begin
        st_d = st_q;
        if (clr_ref) begin
            st_d.refb = '0;
        end
        if (upd_en) begin
            st_d.refb[upd_set][upd_way] = 1'b1;
            if (upd_write) begin
                st_d.dirty[upd_set][upd_way] = 1'b1;
            end
            st_d.lru[upd_set] = ~upd_way;
        end
        if (rf_en) begin
            st_d.vld[rf_set][rf_way_eff]   = 1'b1;
            st_d.dirty[rf_set][rf_way_eff] = 1'b0;
            st_d.refb[rf_set][rf_way_eff]  = 1'b0;
            st_d.rt[rf_set][rf_way_eff]    = rf_rt;
            st_d.tag[rf_set][rf_way_eff]   = rf_tag;
            st_d.ppn[rf_set][rf_way_eff]   = rf_ppn;
            st_d.lru[rf_set]               = ~rf_way_eff;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_REFILL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rf_en |=> st_q.vld[$past(rf_set)][$past(rf_way_eff)]); // R3

    AST_REFILL_MRU: assert property (@(posedge clk) disable iff (!rst_n)
        rf_en |=> st_q.lru[$past(rf_set)] != $past(rf_way_eff)); // R4

    AST_WRITE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_write && !(rf_en && rf_set == upd_set))
        |=> st_q.dirty[$past(upd_set)][$past(upd_way)]); // R5

    AST_CLEAR_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ref && !upd_en) |=> st_q.refb == '0); // R7
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
    import xc_pkg::*;
#(
    parameter  int VA_W  = 40,
    parameter  int PA_W  = 36,
    parameter  int OFF_W = 14,
    parameter  int IDX_W = 8,
    localparam int TAG_W = VA_W - OFF_W - IDX_W,
    localparam int PPN_W = PA_W - OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             lk_write,
    input  logic             lk_exec,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_set,
    input  logic             fill_pick,
    input  logic             fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [1:0]       fill_rights,
    input  logic             ref_clear,
    output logic             rs_valid,
    output logic             rs_hit,
    output logic             rs_trap,
    output logic             rs_fault,
    output logic             rs_way,
    output logic             rs_dirty,
    output logic             rs_ref,
    output logic [PA_W-1:0]  rs_paddr
);
    typedef struct packed {
        logic            valid;
        logic            hit;
        logic            trap;
        logic            fault;
        logic            way;
        logic            dirty;
        logic            refd;
        logic [PA_W-1:0] paddr;
    } result_t;

    result_t res_d, res_q;

    logic [IDX_W-1:0]           req_set;
    logic [TAG_W-1:0]           req_tag;
    logic [OFF_W-1:0]           req_off;
    logic [WAYS-1:0]            rd_vld, rd_dirty, rd_ref;
    logic [WAYS-1:0][TAG_W-1:0] rd_tag;
    logic [WAYS-1:0][PPN_W-1:0] rd_ppn;
    logic [WAYS-1:0][RT_W-1:0]  rd_rt;
    logic [WAYS-1:0]            match_vec, allow_vec;
    logic                       found, hit_way, permitted, upd_en;

    assign req_off = lk_vaddr[OFF_W-1:0];
    assign req_set = lk_vaddr[OFF_W +: IDX_W];
    assign req_tag = lk_vaddr[VA_W-1 -: TAG_W];

    xc_array #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .PPN_W (PPN_W)
    ) i_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_set     (req_set),
        .rd_vld     (rd_vld),
        .rd_tag     (rd_tag),
        .rd_ppn     (rd_ppn),
        .rd_rt      (rd_rt),
        .rd_dirty   (rd_dirty),
        .rd_ref     (rd_ref),
        .upd_en     (upd_en),
        .upd_set    (req_set),
        .upd_way    (hit_way),
        .upd_write  (lk_write),
        .clr_ref    (ref_clear),
        .rf_en      (fill_en),
        .rf_set     (fill_set),
        .rf_use_way (fill_pick),
        .rf_way     (fill_way),
        .rf_tag     (fill_tag),
        .rf_ppn     (fill_ppn),
        .rf_rt      (fill_rights)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        xc_way_cmp #(
            .TAG_W (TAG_W)
        ) i_cmp (
            .ent_vld (rd_vld[w]),
            .ent_tag (rd_tag[w]),
            .ent_rt  (rd_rt[w]),
            .req_tag (req_tag),
            .req_wr  (lk_write),
            .req_ex  (lk_exec),
            .match   (match_vec[w]),
            .allow   (allow_vec[w])
        );
    end

    // Lowest matching way wins if software loaded a duplicate tag.
    always_comb begin
        found   = 1'b0;
        hit_way = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && match_vec[w]) begin
                found   = 1'b1;
                hit_way = 1'(w);
            end
        end
        permitted = allow_vec[hit_way];
        upd_en    = lk_valid && found && permitted;

        res_d       = '0;
        res_d.valid = lk_valid;
        if (lk_valid) begin
            if (!found) begin
                res_d.trap = 1'b1;
            end else if (!permitted) begin
                res_d.fault = 1'b1;
            end else begin
                res_d.hit   = 1'b1;
                res_d.way   = hit_way;
                res_d.dirty = rd_dirty[hit_way];
                res_d.refd  = rd_ref[hit_way];
                res_d.paddr = {rd_ppn[hit_way], req_off};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign rs_valid = res_q.valid;
    assign rs_hit   = res_q.hit;
    assign rs_trap  = res_q.trap;
    assign rs_fault = res_q.fault;
    assign rs_way   = res_q.way;
    assign rs_dirty = res_q.dirty;
    assign rs_ref   = res_q.refd;
    assign rs_paddr = res_q.paddr;

    AST_RESULT_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid); // R1

    AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rs_valid); // R1

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rs_hit || rs_paddr[OFF_W-1:0] == $past(req_off))); // R1

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> $onehot({rs_hit, rs_trap, rs_fault})); // R2

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rs_trap |-> (rs_paddr == '0 && !rs_dirty && !rs_ref && !rs_way)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |-> !(rs_hit || rs_trap || rs_fault)); // R9
endmodule

// File: tb/test_xlate_cache.sv
module test_xlate_cache;
    localparam int VA_W  = 40;
    localparam int PA_W  = 36;
    localparam int OFF_W = 14;
    localparam int IDX_W = 3;
    localparam int TAG_W = VA_W - OFF_W - IDX_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int SETS  = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             lk_valid, lk_write, lk_exec;
    logic [VA_W-1:0]  lk_vaddr;
    logic             fill_en, fill_pick, fill_way, ref_clear;
    logic [IDX_W-1:0] fill_set;
    logic [TAG_W-1:0] fill_tag;
    logic [PPN_W-1:0] fill_ppn;
    logic [1:0]       fill_rights;
    logic             rs_valid, rs_hit, rs_trap, rs_fault, rs_way, rs_dirty, rs_ref;
    logic [PA_W-1:0]  rs_paddr;

    int n_tests = 0;
    int n_fail  = 0;

    // expectation per entry, kept from the requirements
    bit               m_vld  [SETS][2];
    bit               m_dirty[SETS][2];
    bit               m_ref  [SETS][2];
    bit [1:0]         m_rt   [SETS][2];
    bit [TAG_W-1:0]   m_tag  [SETS][2];
    bit [PPN_W-1:0]   m_ppn  [SETS][2];
    bit               m_lru  [SETS];

    always #10 clk = ~clk;

    xlate_cache #(
        .VA_W  (VA_W),
        .PA_W  (PA_W),
        .OFF_W (OFF_W),
        .IDX_W (IDX_W)
    ) i_xlate_cache (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_valid    (lk_valid),
        .lk_vaddr    (lk_vaddr),
        .lk_write    (lk_write),
        .lk_exec     (lk_exec),
        .fill_en     (fill_en),
        .fill_set    (fill_set),
        .fill_pick   (fill_pick),
        .fill_way    (fill_way),
        .fill_tag    (fill_tag),
        .fill_ppn    (fill_ppn),
        .fill_rights (fill_rights),
        .ref_clear   (ref_clear),
        .rs_valid    (rs_valid),
        .rs_hit      (rs_hit),
        .rs_trap     (rs_trap),
        .rs_fault    (rs_fault),
        .rs_way      (rs_way),
        .rs_dirty    (rs_dirty),
        .rs_ref      (rs_ref),
        .rs_paddr    (rs_paddr)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    task automatic idle_inputs();
        lk_valid = 0; lk_write = 0; lk_exec = 0; lk_vaddr = '0;
        fill_en = 0; fill_pick = 0; fill_way = 0; fill_set = '0;
        fill_tag = '0; fill_ppn = '0; fill_rights = '0; ref_clear = 0;
    endtask

    // One cycle: called at a falling edge, returns at the next falling edge.
    task automatic cyc(input string ctx, input bit lk, input int st,
                       input logic [TAG_W-1:0] tg, input logic [OFF_W-1:0] off,
                       input bit wr, input bit ex,
                       input bit rf, input int rset, input bit ruse, input bit rw,
                       input logic [TAG_W-1:0] rtag, input logic [PPN_W-1:0] rppn,
                       input logic [1:0] rrt, input bit clr);
        bit eh = 0, et = 0, ef = 0, ew = 0, ed = 0, er = 0;
        logic [PA_W-1:0] ep = '0;
        bit fnd = 0;
        int hw = 0;
        bit fw;
        if (lk) begin
            for (int w = 0; w < 2; w++) begin
                if (!fnd && m_vld[st][w] && m_tag[st][w] == tg) begin
                    fnd = 1; hw = w;
                end
            end
            if (!fnd) et = 1;
            else if ((wr && !m_rt[st][hw][0]) || (ex && !m_rt[st][hw][1])) ef = 1;
            else begin
                eh = 1; ew = hw[0]; ed = m_dirty[st][hw]; er = m_ref[st][hw];
                ep = {m_ppn[st][hw], off};
            end
        end
        lk_valid = lk; lk_write = wr; lk_exec = ex;
        lk_vaddr = {tg, st[IDX_W-1:0], off};
        fill_en = rf; fill_set = rset[IDX_W-1:0]; fill_pick = ruse; fill_way = rw;
        fill_tag = rtag; fill_ppn = rppn; fill_rights = rrt; ref_clear = clr;
        // apply this cycle's effects after the outcome was predicted
        if (clr) begin
            for (int s = 0; s < SETS; s++) begin
                m_ref[s][0] = 0; m_ref[s][1] = 0;
            end
        end
        if (eh) begin
            m_ref[st][hw] = 1;
            if (wr) m_dirty[st][hw] = 1;
            m_lru[st] = ~hw[0];
        end
        if (rf) begin
            fw = ruse ? rw : m_lru[rset];
            m_vld[rset][fw] = 1; m_dirty[rset][fw] = 0; m_ref[rset][fw] = 0;
            m_rt[rset][fw] = rrt; m_tag[rset][fw] = rtag; m_ppn[rset][fw] = rppn;
            m_lru[rset] = ~fw;
        end
        @(negedge clk);
        check(rs_valid == lk, {ctx, " R1 valid"}, 64'(rs_valid), 64'(lk));
        if (lk) begin
            check(rs_hit   == eh, {ctx, " R1 hit"},    64'(rs_hit),   64'(eh));
            check(rs_trap  == et, {ctx, " R2 trap"},   64'(rs_trap),  64'(et));
            check(rs_fault == ef, {ctx, " R8 fault"},  64'(rs_fault), 64'(ef));
            check(rs_way   == ew, {ctx, " R11 way"},   64'(rs_way),   64'(ew));
            check(rs_dirty == ed, {ctx, " R5 dirty"},  64'(rs_dirty), 64'(ed));
            check(rs_ref   == er, {ctx, " R6 ref"},    64'(rs_ref),   64'(er));
            check(rs_paddr == ep, {ctx, " R1 paddr"},  64'(rs_paddr), 64'(ep));
        end
        idle_inputs();
    endtask

    task automatic look(input string ctx, input int st, input int tg,
                        input int off, input bit wr, input bit ex);
        cyc(ctx, 1, st, TAG_W'(tg), OFF_W'(off), wr, ex, 0, 0, 0, 0, '0, '0, '0, 0);
    endtask

    task automatic fill(input string ctx, input int st, input bit ruse, input bit rw,
                        input int tg, input int ppn, input logic [1:0] rt);
        cyc(ctx, 0, 0, '0, '0, 0, 0, 1, st, ruse, rw, TAG_W'(tg), PPN_W'(ppn), rt, 0);
    endtask

    function automatic int off_of(input int s, input int k);
        return (s * 1237 + k * 4099 + 5) & 16'h3fff;
    endfunction

    initial begin
        idle_inputs();
        rst_n = 0;
        for (int s = 0; s < SETS; s++) begin
            m_lru[s] = 0;
            for (int w = 0; w < 2; w++) begin
                m_vld[s][w] = 0; m_dirty[s][w] = 0; m_ref[s][w] = 0;
                m_rt[s][w] = 0; m_tag[s][w] = 0; m_ppn[s][w] = 0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(rs_valid == 0, "R9 reset valid", 64'(rs_valid), 0);
        check(rs_hit == 0,   "R9 reset hit",   64'(rs_hit),   0);

        // R9: nothing loaded, every set misses
        for (int s = 0; s < SETS; s++) look("R9", s, s * 5 + 100, off_of(s, 0), 0, 0);

        // R3 / R4: even sets use the replacement bit from reset, odd sets name the way
        for (int s = 0; s < SETS; s++) begin
            if (s % 2 == 0) begin
                fill("R4", s, 0, 0, s * 5 + 100, 32'h1000 + s, 2'b01);
                fill("R4", s, 0, 0, s * 5 + 200, 32'h2A000 + s, 2'b10);
            end else begin
                fill("R3", s, 1, 1, s * 5 + 200, 32'h2A000 + s, 2'b10);
                fill("R3", s, 1, 0, s * 5 + 100, 32'h1000 + s, 2'b01);
            end
        end

        // R1 R5 R6 R8 R11: every access kind against both ways of every set
        for (int s = 0; s < SETS; s++) begin
            for (int k = 0; k < 3; k++) begin
                look("R1", s, s * 5 + 100, off_of(s, k), 0, 0);
                look("R1", s, s * 5 + 200, off_of(s, k + 1), 0, 0);
            end
            look("R5", s, s * 5 + 100, off_of(s, 4), 1, 0);
            look("R5", s, s * 5 + 100, off_of(s, 5), 0, 0);
            look("R8", s, s * 5 + 200, off_of(s, 6), 1, 0);
            look("R8", s, s * 5 + 200, off_of(s, 7), 0, 0);
            look("R8", s, s * 5 + 100, off_of(s, 8), 0, 1);
            look("R8", s, s * 5 + 200, off_of(s, 9), 0, 1);
            look("R2", s, s * 5 + 300, off_of(s, 10), 0, 0);
        end

        // R7: clear, then concurrent clear and hit
        cyc("R7", 0, 0, '0, '0, 0, 0, 0, 0, 0, 0, '0, '0, '0, 1);
        for (int s = 0; s < SETS; s++) look("R7", s, s * 5 + 100, off_of(s, 11), 0, 0);
        cyc("R7", 1, 2, TAG_W'(2 * 5 + 200), OFF_W'(77), 0, 0, 0, 0, 0, 0, '0, '0, '0, 1);
        look("R7", 2, 2 * 5 + 200, 78, 0, 0);
        look("R7", 2, 2 * 5 + 100, 79, 0, 0);

        // R4 R8: replacement order, and a fault leaves the bit alone
        for (int s = 0; s < SETS; s++) begin
            look("R4", s, s * 5 + 100, off_of(s, 12), 0, 0);
            fill("R4", s, 0, 0, s * 5 + 400, 32'h3F000 + s, 2'b00);
            look("R4", s, s * 5 + 200, off_of(s, 13), 0, 0);
            look("R4", s, s * 5 + 400, off_of(s, 14), 0, 0);
            look("R8", s, s * 5 + 100, off_of(s, 15), 1, 1);
            look("R8", s, s * 5 + 400, off_of(s, 16), 1, 0);
            fill("R4", s, 0, 0, s * 5 + 500, 32'h15000 + s, 2'b11);
            look("R4", s, s * 5 + 100, off_of(s, 17), 0, 0);
            look("R4", s, s * 5 + 500, off_of(s, 18), 1, 1);
            look("R4", s, s * 5 + 400, off_of(s, 19), 0, 0);
        end

        // R10: a refill in the lookup's cycle is not seen by that lookup
        for (int s = 0; s < SETS; s++) begin
            cyc("R10", 1, s, TAG_W'(s * 5 + 500), OFF_W'(off_of(s, 20)), 0, 0,
                1, s, 1, 0, TAG_W'(s * 5 + 600), PPN_W'(32'h0ABC0 + s), 2'b11, 0);
            look("R10", s, s * 5 + 500, off_of(s, 21), 0, 0);
            look("R10", s, s * 5 + 600, off_of(s, 22), 1, 0);
        end

        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule